// File: doc/BRIEF.md
# Indirect Accelerator Descriptor Read Window

This block answers configuration-register accesses for an indirect window onto a per-accelerator descriptor table. Software selects an accelerator by writing a small index register. It then writes a byte offset into a combined offset/status register. That write starts a fetch from a computed descriptor store. After a programmable number of cycles, the requested 32-bit word appears in a read-only data register and the status bit of the offset register goes high. Software polls that bit and then reads the data register.

Each populated accelerator slot carries a template: a version word, a 24-byte name and a memory-size word. Any other aligned word inside the template length returns a fixed pattern. A slot with no descriptor reads as zero at every offset. So do offsets past the template length and offsets that are not word-aligned. In every one of these cases the fetch still completes with the status bit set.

Top module: `accel_desc_window`

## Requirements
- R1: After reset, the index register, the offset/status register and the data register all read as zero.
- R2: For a populated slot, the word at offset 0x0 holds the template length in bits 31:16, the major version in bits 15:8 and the minor version in bits 7:0. With the default population mask 0x0B (slots 0, 1 and 3 populated), an even slot reads 0x00580100 and an odd slot reads 0x00600101.
- R3: The name occupies offsets 0x4 to 0x1B as six little-endian words. The word at 0x4 holds the bytes 0x61, 0x63, 0x63 and 0x41+slot, from bit 7:0 upward. The words at 0x8 to 0x18 read zero.
- R4: The word at offset 0x3C holds a log2 memory size in bits 7:0, with all other bits zero. The value is 0 (no memory) for slot 0 and 20+slot otherwise.
- R5: A slot whose population-mask bit is clear returns zero data at every offset, including 0x0, and the fetch still sets the status bit.
- R6: An offset at or beyond the template length, or one with bits 1:0 non-zero, returns zero data with the status bit set. Any other aligned in-range offset returns {0xD0, slot, offset[15:0]}.
- R7: From the cycle after an offset write, the status bit (bit 31 of the offset/status register) is clear and the data register reads zero until the fetch completes.
- R8: The status bit rises exactly LATENCY clock cycles after the clock edge that accepts the offset write. After that, the status bit and the data hold until the next offset write.
- R9: Bit 31 of a value written to the offset/status register is discarded. Such a write reads back with bit 31 clear and cannot set the status bit.
- R10: An offset write during an in-flight fetch abandons that fetch. The status bit then rises LATENCY cycles after the new write, with the word for the new offset.
- R11: The index register is written through byte lane 0, keeps only its low 6 bits and reads back with bits 31:6 zero. Writing it does not disturb the status bit or the data. A fetch uses the index held when its offset was written.
- R12: Offset writes honour the byte enables, merging only the enabled bytes into the stored offset. Any offset write with at least one byte enabled starts a fetch. Writes to the data register have no effect.
- R13: Register addresses are 0 = index, 1 = offset/status, 2 = data; address 3 reads zero, and cfg_rdata is zero whenever cfg_rd is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 2 | Register word address |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, combinational from register state |

## Verification
The hardest situation to reach is an offset write that lands while an earlier fetch is still counting down. It is made harder when the index register also changes in mid-flight. The directed scenarios create both cases by issuing a second register write a fixed number of cycles after the first. They then check that the status bit stays low at the exact cycle the first fetch would have completed. The returned word must belong to the offset and index that were current at the latest offset write. The template boundary is reached by reading offset 0x58 on slots of both template lengths.

// File: rtl/accel_desc_pkg.sv
package accel_desc_pkg;

  localparam int WORD_W = 32;
  localparam int OFF_W  = 31;

  typedef enum logic [1:0] {
    REG_INDEX  = 2'd0,
    REG_OFFSET = 2'd1,
    REG_DATA   = 2'd2,
    REG_SPARE  = 2'd3
  } cfg_reg_e;

  localparam logic [15:0] TLEN_SHORT = 16'h0058;
  localparam logic [15:0] TLEN_LONG  = 16'h0060;

  localparam logic [OFF_W-1:0] OFFS_VERSION  = 31'h00;
  localparam logic [OFF_W-1:0] OFFS_NAME     = 31'h04;
  localparam logic [OFF_W-1:0] OFFS_NAME_END = 31'h1C;
  localparam logic [OFF_W-1:0] OFFS_MEMLOG   = 31'h3C;

  localparam logic [7:0] FILL_TAG = 8'hD0;

endpackage

// File: rtl/accel_cfg_regs.sv
module accel_cfg_regs
  import accel_desc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [1:0]        cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              fetch_valid,
  input  logic [WORD_W-1:0] fetch_data,
  output logic [IDX_W-1:0]  idx_q,
  output logic [OFF_W-1:0]  off_next,
  output logic              off_start,
  output logic [WORD_W-1:0] cfg_rdata
);

  logic [OFF_W-1:0]  off_q;
  logic [IDX_W-1:0]  idx_d;
  logic              idx_en;
  logic [WORD_W-1:0] lane_mask;

  // write decode
  always_comb begin
    off_start = cfg_wr && (cfg_reg_e'(cfg_addr) == REG_OFFSET) && (|cfg_be);
    idx_en    = cfg_wr && (cfg_reg_e'(cfg_addr) == REG_INDEX) && cfg_be[0];
    idx_d     = cfg_wdata[IDX_W-1:0];
  end

  // byte-lane merge; the status position is dropped by the narrowing cast
  always_comb begin
    for (int b = 0; b < 4; b++) begin
      lane_mask[8*b +: 8] = {8{cfg_be[b]}};
    end
    if (off_start) begin
      off_next = OFF_W'(({1'b0, off_q} & ~lane_mask) | (cfg_wdata & lane_mask));
    end else begin
      off_next = off_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (off_start) begin
      off_q <= off_next;
    end
  end

  // read mux
  always_comb begin
    cfg_rdata = '0;
    if (cfg_rd) begin
      case (cfg_reg_e'(cfg_addr))
        REG_INDEX:  cfg_rdata = WORD_W'(idx_q);
        REG_OFFSET: cfg_rdata = {fetch_valid, off_q};
        REG_DATA:   cfg_rdata = fetch_data;
        default:    cfg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/accel_desc_rom.sv
module accel_desc_rom
  import accel_desc_pkg::*;
#(
  parameter int                 NUM_SLOTS = 64,
  parameter logic [NUM_SLOTS-1:0] POP_MASK = NUM_SLOTS'(64'h0B),
  localparam int                IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic [IDX_W-1:0]  slot,
  input  logic [OFF_W-1:0]  offset,
  output logic [WORD_W-1:0] word
);

  logic        populated;
  logic [15:0] tlen;
  logic [7:0]  slot8;
  logic [7:0]  name_hi;
  logic [7:0]  mem_log;
  logic        in_window;
  logic [WORD_W-1:0] sel;

  always_comb begin
    populated = POP_MASK[slot];
    slot8     = 8'(slot);
    tlen      = populated ? (slot[0] ? TLEN_LONG : TLEN_SHORT) : 16'h0;
    name_hi   = 8'(8'h41 + slot8);
    mem_log   = (slot8 == 8'h0) ? 8'h0 : 8'(8'd20 + slot8);
    in_window = populated && (offset[1:0] == 2'b00) && (offset < OFF_W'(tlen));

    if (offset == OFFS_VERSION) begin
      sel = {tlen, 8'h01, 7'b0, slot[0]};
    end else if (offset == OFFS_NAME) begin
      sel = {name_hi, 8'h63, 8'h63, 8'h61};
    end else if (offset < OFFS_NAME_END) begin
      sel = '0;
    end else if (offset == OFFS_MEMLOG) begin
      sel = {24'h0, mem_log};
    end else begin
      sel = {FILL_TAG, slot8, offset[15:0]};
    end

    word = in_window ? sel : '0;
  end

endmodule

// File: rtl/accel_fetch_seq.sv
module accel_fetch_seq
  import accel_desc_pkg::*;
#(
  parameter int  LATENCY = 4,
  parameter int  IDX_W   = 6,
  localparam int CNT_W   = $clog2(LATENCY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic [OFF_W-1:0]  off_in,
  input  logic [WORD_W-1:0] rom_word,
  output logic [IDX_W-1:0]  req_idx,
  output logic [OFF_W-1:0]  req_off,
  output logic [CNT_W-1:0]  cnt,
  output logic              valid,
  output logic [WORD_W-1:0] data
);

  logic [CNT_W-1:0]  cnt_d;
  logic              valid_d;
  logic [WORD_W-1:0] data_d;
  logic              state_en;

  always_comb begin
    cnt_d    = cnt;
    valid_d  = valid;
    data_d   = data;
    state_en = 1'b0;
    if (start) begin
      cnt_d    = CNT_W'(LATENCY);
      valid_d  = 1'b0;
      data_d   = '0;
      state_en = 1'b1;
    end else if (cnt != '0) begin
      cnt_d    = cnt - 1'b1;
      state_en = 1'b1;
      if (cnt == CNT_W'(1)) begin
        valid_d = 1'b1;
        data_d  = rom_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else if (state_en) begin
      cnt   <= cnt_d;
      valid <= valid_d;
      data  <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_idx <= '0;
      req_off <= '0;
    end else if (start) begin
      req_idx <= idx_in;
      req_off <= off_in;
    end
  end

endmodule

// File: rtl/accel_desc_window.sv
module accel_desc_window
  import accel_desc_pkg::*;
#(
  parameter int                   NUM_SLOTS = 64,
  parameter int                   LATENCY   = 4,
  parameter logic [NUM_SLOTS-1:0] POP_MASK  = NUM_SLOTS'(64'h0B)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [1:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata
);

  localparam int IDX_W = $clog2(NUM_SLOTS);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [IDX_W-1:0]  idx_q;
  logic [OFF_W-1:0]  off_next;
  logic              off_start;
  logic [IDX_W-1:0]  req_idx;
  logic [OFF_W-1:0]  req_off;
  logic [WORD_W-1:0] rom_word;
  logic [CNT_W-1:0]  fetch_cnt;
  logic              fetch_valid;
  logic [WORD_W-1:0] fetch_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  accel_cfg_regs #(.IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_wr     (cfg_wr),
    .cfg_rd     (cfg_rd),
    .cfg_addr   (cfg_addr),
    .cfg_be     (cfg_be),
    .cfg_wdata  (cfg_wdata),
    .fetch_valid(fetch_valid),
    .fetch_data (fetch_data),
    .idx_q      (idx_q),
    .off_next   (off_next),
    .off_start  (off_start),
    .cfg_rdata  (cfg_rdata)
  );

  accel_fetch_seq #(.LATENCY(LATENCY), .IDX_W(IDX_W)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (off_start),
    .idx_in  (idx_q),
    .off_in  (off_next),
    .rom_word(rom_word),
    .req_idx (req_idx),
    .req_off (req_off),
    .cnt     (fetch_cnt),
    .valid   (fetch_valid),
    .data    (fetch_data)
  );

  accel_desc_rom #(.NUM_SLOTS(NUM_SLOTS), .POP_MASK(POP_MASK)) u_rom (
    .slot  (req_idx),
    .offset(req_off),
    .word  (rom_word)
  );

endmodule

// File: rtl/accel_desc_window_chk.sv
module accel_desc_window_chk #(
  parameter int LATENCY = 4,
  parameter int IDX_W   = 6,
  parameter int CNT_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             valid,
  input logic [31:0]      data,
  input logic [CNT_W-1:0] cnt,
  input logic             cfg_rd,
  input logic [1:0]       cfg_addr,
  input logic [31:0]      cfg_rdata
);

  assert_clear_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!valid && data == 32'h0));

  assert_pending_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> data == 32'h0);

  assert_hold_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !start) |=> (valid && $stable(data)));

  assert_rise_on_last_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(cnt) == CNT_W'(1));

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(LATENCY));

  assert_index_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_addr == 2'd0) |-> (cfg_rdata >> IDX_W) == 32'h0);

endmodule

bind accel_desc_window accel_desc_window_chk #(
  .LATENCY(LATENCY), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start    (off_start),
  .valid    (fetch_valid),
  .data     (fetch_data),
  .cnt      (fetch_cnt),
  .cfg_rd   (cfg_rd),
  .cfg_addr (cfg_addr),
  .cfg_rdata(cfg_rdata)
);

// File: tb/tb_accel_desc_window.sv
module tb_accel_desc_window;

  localparam int LAT = 4;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic        cfg_rd;
  logic [1:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;

  int checks;
  int failures;
  bit done;

  accel_desc_window #(.NUM_SLOTS(64), .LATENCY(LAT), .POP_MASK(64'h0B)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0; cfg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    cfg_rd = 1'b1; cfg_addr = a;
    #1;
    d = cfg_rdata;
    cfg_rd = 1'b0;
  endtask

  task automatic fetch_check(input string req, input logic [6:0] idx, input logic [31:0] off,
                             input logic [31:0] exp);
    logic [31:0] v;
    wr(2'd0, 4'h1, {25'h0, idx});
    wr(2'd1, 4'hF, off);
    repeat (LAT) @(negedge clk);
    rd(2'd1, v);
    check(req, v[31], 1'b1);
    rd(2'd2, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd0, v); check("R1 index", v, 32'h0);
    rd(2'd1, v); check("R1 status", v, 32'h0);
    rd(2'd2, v); check("R1 data", v, 32'h0);
  endtask

  task automatic t_version;
    fetch_check("R2 slot0", 7'd0, 32'h0, 32'h0058_0100);
    fetch_check("R2 slot1", 7'd1, 32'h0, 32'h0060_0101);
    fetch_check("R2 slot3", 7'd3, 32'h0, 32'h0060_0101);
  endtask

  task automatic t_name;
    fetch_check("R3 slot1 first", 7'd1, 32'h4, 32'h4263_6361);
    fetch_check("R3 slot3 first", 7'd3, 32'h4, 32'h4463_6361);
    fetch_check("R3 slot1 pad", 7'd1, 32'h8, 32'h0);
    fetch_check("R3 slot0 last", 7'd0, 32'h18, 32'h0);
  endtask

  task automatic t_memlog;
    fetch_check("R4 slot0", 7'd0, 32'h3C, 32'h0);
    fetch_check("R4 slot1", 7'd1, 32'h3C, 32'h15);
    fetch_check("R4 slot3", 7'd3, 32'h3C, 32'h17);
  endtask

  task automatic t_unpopulated;
    logic [31:0] v;
    fetch_check("R5 slot2 ver", 7'd2, 32'h0, 32'h0);
    fetch_check("R5 slot2 name", 7'd2, 32'h4, 32'h0);
    fetch_check("R5 slot63", 7'd63, 32'h0, 32'h0);
    rd(2'd1, v); check("R5 status", v, 32'h8000_0000);
  endtask

  task automatic t_range;
    fetch_check("R6 short edge", 7'd0, 32'h58, 32'h0);
    fetch_check("R6 long inside", 7'd1, 32'h58, 32'hD001_0058);
    fetch_check("R6 long last", 7'd1, 32'h5C, 32'hD001_005C);
    fetch_check("R6 long edge", 7'd1, 32'h60, 32'h0);
    fetch_check("R6 unaligned", 7'd1, 32'h5, 32'h0);
    fetch_check("R6 fill", 7'd3, 32'h1C, 32'hD003_001C);
  endtask

  task automatic t_timing;
    logic [31:0] v;
    wr(2'd0, 4'h1, 32'h1);
    wr(2'd1, 4'hF, 32'h0);
    rd(2'd1, v); check("R7 status cleared", v, 32'h0);
    rd(2'd2, v); check("R7 data cleared", v, 32'h0);
    repeat (LAT - 1) @(negedge clk);
    rd(2'd1, v); check("R8 not yet", v, 32'h0);
    @(negedge clk);
    rd(2'd1, v); check("R8 on time", v, 32'h8000_0000);
    repeat (20) @(negedge clk);
    rd(2'd2, v); check("R8 hold", v, 32'h0060_0101);
  endtask

  task automatic t_bit31;
    logic [31:0] v;
    wr(2'd0, 4'h1, 32'h1);
    wr(2'd1, 4'hF, 32'h8000_0004);
    rd(2'd1, v); check("R9 no force", v, 32'h0000_0004);
    repeat (LAT) @(negedge clk);
    rd(2'd1, v); check("R9 done", v, 32'h8000_0004);
    rd(2'd2, v); check("R9 data", v, 32'h4263_6361);
  endtask

  task automatic t_abort;
    logic [31:0] v;
    wr(2'd0, 4'h1, 32'h1);
    wr(2'd1, 4'hF, 32'h0);
    repeat (2) @(negedge clk);
    wr(2'd1, 4'hF, 32'h3C);
    rd(2'd1, v); check("R10 first dropped", v, 32'h0000_003C);
    repeat (LAT - 1) @(negedge clk);
    rd(2'd1, v); check("R10 still pending", v, 32'h0000_003C);
    @(negedge clk);
    rd(2'd1, v); check("R10 restarted", v, 32'h8000_003C);
    rd(2'd2, v); check("R10 data", v, 32'h15);
  endtask

  task automatic t_index;
    logic [31:0] v;
    wr(2'd0, 4'h1, 32'hFFFF_FFC2);
    rd(2'd0, v); check("R11 mask", v, 32'h2);
    wr(2'd0, 4'h2, 32'h0000_0100);
    rd(2'd0, v); check("R11 lane", v, 32'h2);
    wr(2'd0, 4'h1, 32'h0);
    wr(2'd1, 4'hF, 32'h0);
    wr(2'd0, 4'h1, 32'h1);
    repeat (LAT) @(negedge clk);
    rd(2'd2, v); check("R11 captured", v, 32'h0058_0100);
    wr(2'd0, 4'h1, 32'h3);
    rd(2'd1, v); check("R11 status kept", v, 32'h8000_0000);
    rd(2'd2, v); check("R11 data kept", v, 32'h0058_0100);
  endtask

  task automatic t_lanes;
    logic [31:0] v;
    wr(2'd0, 4'h1, 32'h1);
    wr(2'd1, 4'hF, 32'h0001_0204);
    repeat (LAT) @(negedge clk);
    wr(2'd1, 4'h1, 32'hFFFF_FF3C);
    rd(2'd1, v); check("R12 merge", v, 32'h0001_023C);
    wr(2'd1, 4'hE, 32'h0000_003C);
    rd(2'd1, v); check("R12 upper", v, 32'h0000_003C);
    repeat (LAT) @(negedge clk);
    rd(2'd2, v); check("R12 fetch", v, 32'h15);
    wr(2'd2, 4'hF, 32'hDEAD_BEEF);
    rd(2'd2, v); check("R12 data ro", v, 32'h15);
    rd(2'd1, v); check("R12 status ro", v, 32'h8000_003C);
  endtask

  task automatic t_map;
    logic [31:0] v;
    rd(2'd3, v); check("R13 spare", v, 32'h0);
    cfg_addr = 2'd2; cfg_rd = 1'b0;
    #1;
    check("R13 gate", cfg_rdata, 32'h0);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_rd = 1'b0;
    cfg_addr = 2'd0; cfg_be = 4'h0; cfg_wdata = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_version();
    t_name();
    t_memlog();
    t_unpopulated();
    t_range();
    t_timing();
    t_bit31();
    t_abort();
    t_index();
    t_lanes();
    t_map();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule